// File: doc/BRIEF.md
# Flash sector protection controller

This block sits between a flash command front end and a 512-Kbyte array. It decides whether each request may proceed. A request carries a 19-bit byte address and one of four operations: read, program, erase under the boot-partitioned sector map, or erase under the uniform 64-Kbyte map. The decision uses two hardware protect pins and a bank of per-sector lock registers that software writes. Exactly one cycle after the request, the block returns a grant or deny flag. For an erase it also returns the first and last byte address of the region the erase would clear. For a read it passes the array byte through, or returns FFh when the read is refused.

In the partitioned map there are eleven sectors. Sectors 4 to 10 are the 64-Kbyte blocks 1 to 7, and sector 10 is the top boot sector at 070000h–07FFFFh. The lowest 64 Kbyte is split into sector 3 (32K at 008000h), sector 2 (16K at 004000h), sector 1 (8K at 002000h) and sector 0 (8K at 000000h). The boot pin guards only sector 10. The write-protect pin guards every other sector.

The reset and initialise inputs are synchronous, active low and equivalent. While either is low, no response is issued and every lock is cleared. The interface-select level is captured while reset is held and kept after release.

Top module: `sector_guard`

## Requirements
- R1: A partitioned erase (op 2'b10) reports first/last bounds of the sector holding the address: 64K blocks for addresses at or above 010000h, then 008000h–00FFFFh, 004000h–007FFFh, 002000h–003FFFh and 000000h–001FFFh.
- R2: A uniform erase (op 2'b11) reports first = {addr[18:16], 16'h0000} and last = {addr[18:16], 16'hFFFF}.
- R3: While boot_lock_n is low, every program (op 2'b01) or erase aimed at 070000h–07FFFFh is denied, whatever the lock registers hold; other sectors are unaffected.
- R4: While boot_lock_n is high, a set write-lock on sector 10 still denies program and erase there; the level or a toggle of boot_lock_n never changes any lock register.
- R5: While wp_n is low, program and erase to any sector other than sector 10 are denied; sector 10 stays writable.
- R6: A lock write (lk_we, lk_sector = index, lk_data bit 0 = write lock, bit 1 = read lock) with bit 0 set denies program and erase of that sector only.
- R7: A read (op 2'b00) from a sector whose read-lock bit is set is denied with rd_data = FFh; otherwise it is granted with rd_data = arr_data. The write lock does not block reads, and the read lock does not block writes.
- R8: A uniform erase of block 0 (000000h–00FFFFh) is denied if any of sectors 0 to 3 is write-locked by its register or by wp_n low.
- R9: While rst_n or init_n is low, no response is issued (rsp_valid low) and all locks are cleared; the two inputs act identically.
- R10: host_mode follows iface_sel only while reset is held, and stays constant while reset is released.
- R11: A lock write with lk_sector of 11 or more changes no lock.
- R12: Each accepted request gives rsp_valid high for exactly one cycle, on the clock edge after the request, with exactly one of rsp_grant and rsp_deny set; rsp_first/rsp_last are zero for non-erase operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_n | input | 1 | Second active-low reset, same effect |
| iface_sel | input | 1 | Interface-select level, captured during reset |
| boot_lock_n | input | 1 | Active-low hardware lock of the top boot sector |
| wp_n | input | 1 | Active-low hardware write protect of all other sectors |
| lk_we | input | 1 | Lock register write strobe |
| lk_sector | input | 4 | Sector index for the lock write |
| lk_data | input | 2 | Bit 1 read lock, bit 0 write lock |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 read, 01 program, 10 partitioned erase, 11 uniform erase |
| req_addr | input | 19 | Byte address |
| arr_data | input | 8 | Array byte for the current read |
| rsp_valid | output | 1 | Response strobe |
| rsp_grant | output | 1 | Request allowed |
| rsp_deny | output | 1 | Request refused |
| rsp_first | output | 19 | First address of the erase region |
| rsp_last | output | 19 | Last address of the erase region |
| rd_data | output | 8 | Read data, FFh when refused |
| host_mode | output | 1 | Captured interface-select level |

## Verification
The bench probes the edges of the non-uniform map, such as 003000h against 002000h and 009000h against 008000h. A decoder off by one bit there would report the wrong neighbour's bounds. It checks that a uniform erase of block 0 is refused when only the 16K sub-sector is locked; a design that looked only at the addressed sector would let it through. It toggles the boot pin around a set register lock to show the lock survives and the pin never reaches sector 0. It also pulses init_n alone to catch a design that cleared locks only on rst_n.

// File: rtl/sg_pkg.sv
// Shared constants and types for the sector protection controller.
// Assumes a 512-Kbyte array with a 64-Kbyte top boot sector.
package sg_pkg;
    localparam int ADDR_W   = 19;                          // byte address width
    localparam int BIG_SH   = 16;                          // log2 of a main sector
    localparam int SUB_LO   = 13;                          // log2 of the smallest sub-sector
    localparam int SUB_SECT = BIG_SH - SUB_LO + 1;         // sectors inside block 0
    localparam int SECT_CNT = (1 << (ADDR_W - BIG_SH)) - 1 + SUB_SECT;
    localparam int SECT_W   = 4;                           // sector index width

    typedef enum logic [1:0] {
        OP_READ       = 2'b00,
        OP_PROG       = 2'b01,
        OP_ERASE_PART = 2'b10,
        OP_ERASE_UNI  = 2'b11
    } op_e;

    typedef struct packed {
        logic rd_lock;
        logic wr_lock;
    } lock_t;
endpackage

// File: rtl/sg_sector_map.sv
// Address decoder: maps a byte address to its partitioned sector index and
// returns the bounds of that sector and of its uniform 64-Kbyte block.
// Assumes sub-sectors halve in size going down from bit BIG_SH-1 to SUB_LO.
module sg_sector_map
    import sg_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0]        addr,
    output logic [SECT_W-1:0]    sect_idx,
    output logic [AW-BIG_SH-1:0] blk,
    output logic [AW-1:0]        part_first,
    output logic [AW-1:0]        part_last,
    output logic [AW-1:0]        uni_first,
    output logic [AW-1:0]        uni_last
);
    localparam int BW = AW - BIG_SH;

    assign blk       = addr[AW-1:BIG_SH];
    assign uni_first = {blk, {BIG_SH{1'b0}}};
    assign uni_last  = {blk, {BIG_SH{1'b1}}};

    // Purpose: find the sector and its bounds, main blocks first, then sub-sectors.
    always_comb begin
        if (blk != '0) begin
            sect_idx   = SECT_W'(blk) + SECT_W'(SUB_SECT - 1);
            part_first = uni_first;
            part_last  = uni_last;
        end else begin
            sect_idx   = '0;
            part_first = '0;
            part_last  = (AW'(1) << SUB_LO) - AW'(1);
            for (int k = SUB_LO; k < BIG_SH; k++) begin
                if (addr[k]) begin
                    sect_idx   = SECT_W'(k - SUB_LO + 1);
                    part_first = AW'(1) << k;
                    part_last  = (AW'(2) << k) - AW'(1);
                end
            end
        end
    end

    // R1: the decoded sector must contain the address.
    always_comb begin
        assert_in_sector_R1: assert (part_first <= addr && addr <= part_last);
    end
endmodule

// File: rtl/sg_lock_bank.sv
// Per-sector lock registers. Cleared while the block is held in reset.
// Writes to an index beyond the last sector are dropped.
module sg_lock_bank
    import sg_pkg::*;
#(
    parameter int N = SECT_CNT
) (
    input  logic                 clk,
    input  logic                 live,
    input  logic                 wr_en,
    input  logic [SECT_W-1:0]    wr_idx,
    input  lock_t                wr_val,
    output lock_t [N-1:0]        locks
);
    for (genvar g = 0; g < N; g++) begin : g_sect
        // Purpose: hold one sector's lock bits, cleared in reset.
        always_ff @(posedge clk) begin
            if (!live)
                locks[g] <= '0;
            else if (wr_en && wr_idx == SECT_W'(g))
                locks[g] <= wr_val;
        end
    end

    assert_bad_index_R11: assert property (@(posedge clk) disable iff (!live)
        $past(live && wr_en && wr_idx >= SECT_W'(N)) |-> locks == $past(locks));

    assert_reset_clear_R9: assert property (@(posedge clk)
        !live |=> locks == '0);
endmodule

// File: rtl/sg_decide.sv
// Grant decision: combines hardware pins with the lock registers.
// The top sector is guarded by boot_lock_n; all others by wp_n.
module sg_decide
    import sg_pkg::*;
#(
    parameter int N  = SECT_CNT,
    parameter int BW = ADDR_W - BIG_SH
) (
    input  op_e               op,
    input  logic [SECT_W-1:0] sect_idx,
    input  logic [BW-1:0]     blk,
    input  lock_t [N-1:0]     locks,
    input  logic              boot_lock_n,
    input  logic              wp_n,
    output logic              grant
);
    logic [N-1:0] wr_block;

    for (genvar g = 0; g < N; g++) begin : g_blk
        if (g == N - 1) begin : g_top
            assign wr_block[g] = !boot_lock_n || locks[g].wr_lock;
        end else begin : g_rest
            assign wr_block[g] = !wp_n || locks[g].wr_lock;
        end
    end

    // Purpose: select the rule that applies to this operation.
    always_comb begin
        unique case (op)
            OP_READ:      grant = !locks[sect_idx].rd_lock;
            OP_ERASE_UNI: grant = (blk == '0) ? !(|wr_block[SUB_SECT-1:0])
                                              : !wr_block[sect_idx];
            default:      grant = !wr_block[sect_idx];
        endcase
    end
endmodule

// File: rtl/sector_guard.sv
// Top of the sector protection controller. Registers one response per request.
// Assumes rst_n and init_n are synchronous; either low resets the block.
module sector_guard
    import sg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_n,
    input  logic          iface_sel,
    input  logic          boot_lock_n,
    input  logic          wp_n,
    input  logic          lk_we,
    input  logic [3:0]    lk_sector,
    input  logic [1:0]    lk_data,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] arr_data,
    output logic          rsp_valid,
    output logic          rsp_grant,
    output logic          rsp_deny,
    output logic [AW-1:0] rsp_first,
    output logic [AW-1:0] rsp_last,
    output logic [DW-1:0] rd_data,
    output logic          host_mode
);
    localparam int BW = AW - BIG_SH;

    logic                 live;
    op_e                  op;
    logic [SECT_W-1:0]    sect_idx;
    logic [BW-1:0]        blk;
    logic [AW-1:0]        part_first, part_last, uni_first, uni_last;
    lock_t [SECT_CNT-1:0] locks;
    logic                 grant;

    assign live = rst_n && init_n;
    assign op   = op_e'(req_op);

    sg_sector_map #(.AW(AW)) map_i (
        .addr(req_addr), .sect_idx(sect_idx), .blk(blk),
        .part_first(part_first), .part_last(part_last),
        .uni_first(uni_first), .uni_last(uni_last)
    );

    sg_lock_bank #(.N(SECT_CNT)) bank_i (
        .clk(clk), .live(live), .wr_en(lk_we), .wr_idx(lk_sector),
        .wr_val(lock_t'(lk_data)), .locks(locks)
    );

    sg_decide #(.N(SECT_CNT), .BW(BW)) dec_i (
        .op(op), .sect_idx(sect_idx), .blk(blk), .locks(locks),
        .boot_lock_n(boot_lock_n), .wp_n(wp_n), .grant(grant)
    );

    // Purpose: register the response for the request seen this cycle.
    always_ff @(posedge clk) begin
        if (!live || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_deny  <= 1'b0;
            rsp_first <= '0;
            rsp_last  <= '0;
            rd_data   <= '1;
        end else begin
            rsp_valid <= 1'b1;
            rsp_grant <= grant;
            rsp_deny  <= !grant;
            rd_data   <= (op == OP_READ && grant) ? arr_data : '1;
            unique case (op)
                OP_ERASE_PART: begin rsp_first <= part_first; rsp_last <= part_last; end
                OP_ERASE_UNI:  begin rsp_first <= uni_first;  rsp_last <= uni_last;  end
                default:       begin rsp_first <= '0;         rsp_last <= '0;        end
            endcase
        end
    end

    // Purpose: capture the interface-select level while reset is held.
    always_ff @(posedge clk) begin
        if (!live)
            host_mode <= iface_sel;
    end

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !live |=> !rsp_valid);

    assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!live)
        $past(live) |-> rsp_valid == $past(req_valid));

    assert_flag_pair_R12: assert property (@(posedge clk) disable iff (!live)
        rsp_valid |-> (rsp_grant != rsp_deny));

    assert_boot_pin_R3: assert property (@(posedge clk) disable iff (!live)
        $past(live && req_valid && req_op != 2'b00 && !boot_lock_n
              && req_addr[AW-1:BIG_SH] == '1) |-> rsp_deny);

    assert_wp_pin_R5: assert property (@(posedge clk) disable iff (!live)
        $past(live && req_valid && req_op != 2'b00 && !wp_n
              && req_addr[AW-1:BIG_SH] != '1) |-> rsp_deny);

    assert_read_fill_R7: assert property (@(posedge clk) disable iff (!live)
        $past(live && req_valid && req_op == 2'b00) && rsp_deny |-> rd_data == '1);

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!live)
        $past(live) |-> $stable(host_mode));
endmodule

// File: tb/sector_guard_tb.sv
module sector_guard_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, init_n = 1'b1, iface_sel = 1'b1;
    logic        boot_lock_n = 1'b1, wp_n = 1'b1;
    logic        lk_we = 1'b0;
    logic [3:0]  lk_sector = '0;
    logic [1:0]  lk_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [18:0] req_addr = '0;
    logic [7:0]  arr_data = '0;
    logic        rsp_valid, rsp_grant, rsp_deny, host_mode;
    logic [18:0] rsp_first, rsp_last;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [1:0] RD = 2'b00, PG = 2'b01, EP = 2'b10, EU = 2'b11;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_guard dut_i (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .iface_sel(iface_sel),
        .boot_lock_n(boot_lock_n), .wp_n(wp_n), .lk_we(lk_we),
        .lk_sector(lk_sector), .lk_data(lk_data), .req_valid(req_valid),
        .req_op(req_op), .req_addr(req_addr), .arr_data(arr_data),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_deny(rsp_deny),
        .rsp_first(rsp_first), .rsp_last(rsp_last), .rd_data(rd_data),
        .host_mode(host_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one request; outputs are sampled at the negedge after capture.
    task automatic issue(input logic [1:0] op, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; arr_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_lock(input logic [3:0] s, input logic [1:0] v);
        @(negedge clk);
        lk_we = 1'b1; lk_sector = s; lk_data = v;
        @(negedge clk);
        lk_we = 1'b0;
    endtask

    task automatic expect_grant(input string tag, input logic [1:0] op,
                                input logic [18:0] a, input logic g);
        issue(op, a, 8'h00);
        chk(tag, {rsp_valid, rsp_grant, rsp_deny}, {1'b1, g, !g});
    endtask

    // Independent model of the partitioned sector bounds.
    function automatic logic [37:0] part_bounds(input logic [18:0] a);
        if (a >= 19'h10000) return {a & 19'h70000, (a & 19'h70000) | 19'h0FFFF};
        if (a >= 19'h08000) return {19'h08000, 19'h0FFFF};
        if (a >= 19'h04000) return {19'h04000, 19'h07FFF};
        if (a >= 19'h02000) return {19'h02000, 19'h03FFF};
        return {19'h00000, 19'h01FFF};
    endfunction

    task automatic t_reset_state();
        @(negedge clk);
        req_valid = 1'b1; req_op = PG; req_addr = 19'h12345;
        @(negedge clk);
        chk("R9 no response in reset", rsp_valid, 0);
        chk("R10 mode captured in reset", host_mode, 1);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle after reset", rsp_valid, 0);
    endtask

    task automatic t_part_map();
        logic [18:0] addrs [6] = '{19'h7ABCD, 19'h12345, 19'h09000,
                                   19'h05555, 19'h03000, 19'h00010};
        foreach (addrs[i]) begin
            logic [37:0] b;
            b = part_bounds(addrs[i]);
            issue(EP, addrs[i], 8'h00);
            chk("R1 part first", rsp_first, b[37:19]);
            chk("R1 part last", rsp_last, b[18:0]);
            chk("R12 grant pair", {rsp_valid, rsp_grant, rsp_deny}, 3'b110);
        end
        @(negedge clk);
        chk("R12 single cycle", rsp_valid, 0);
    endtask

    task automatic t_uni_map();
        issue(EU, 19'h0ABCD, 8'h00);
        chk("R2 uni first blk0", rsp_first, 19'h00000);
        chk("R2 uni last blk0", rsp_last, 19'h0FFFF);
        issue(EU, 19'h5F000, 8'h00);
        chk("R2 uni first blk5", rsp_first, 19'h50000);
        chk("R2 uni last blk5", rsp_last, 19'h5FFFF);
        issue(PG, 19'h5F000, 8'h00);
        chk("R12 program range zero", {rsp_first, rsp_last}, 38'h0);
    endtask

    task automatic t_locks();
        set_lock(4'd2, 2'b01);
        expect_grant("R6 write lock denies", PG, 19'h04100, 1'b0);
        expect_grant("R6 neighbour free", PG, 19'h02100, 1'b1);
        issue(RD, 19'h04100, 8'h5A);
        chk("R7 write lock keeps read", {rsp_grant, rd_data}, {1'b1, 8'h5A});
        set_lock(4'd5, 2'b10);
        issue(RD, 19'h20010, 8'h33);
        chk("R7 read lock fill", {rsp_deny, rd_data}, {1'b1, 8'hFF});
        expect_grant("R7 read lock keeps write", PG, 19'h20010, 1'b1);
    endtask

    task automatic t_uni_block0();
        expect_grant("R8 block0 denied by sub lock", EU, 19'h00000, 1'b0);
        expect_grant("R8 block1 free", EU, 19'h10000, 1'b1);
        expect_grant("R8 part erase sector0 free", EP, 19'h00000, 1'b1);
    endtask

    task automatic t_bad_index();
        for (int s = 11; s < 16; s++) set_lock(4'(s), 2'b11);
        expect_grant("R11 top sector unchanged", PG, 19'h70000, 1'b1);
        expect_grant("R11 sector0 unchanged", PG, 19'h00000, 1'b1);
        expect_grant("R11 sector0 read", RD, 19'h00000, 1'b1);
    endtask

    task automatic t_reset_clear();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        expect_grant("R9 rst clears lock", PG, 19'h04100, 1'b1);
        expect_grant("R9 rst clears read lock", RD, 19'h20010, 1'b1);
    endtask

    task automatic t_wp();
        wp_n = 1'b0;
        expect_grant("R5 wp sector0", PG, 19'h00000, 1'b0);
        expect_grant("R5 wp sector9", EP, 19'h6FFFF, 1'b0);
        expect_grant("R8 wp block0 uni", EU, 19'h00000, 1'b0);
        expect_grant("R5 wp spares top", PG, 19'h70000, 1'b1);
        expect_grant("R5 wp read ok", RD, 19'h00000, 1'b1);
        wp_n = 1'b1;
        expect_grant("R5 wp released", PG, 19'h00000, 1'b1);
    endtask

    task automatic t_boot();
        boot_lock_n = 1'b0;
        expect_grant("R3 boot program", PG, 19'h7FFFF, 1'b0);
        expect_grant("R3 boot part erase", EP, 19'h70000, 1'b0);
        expect_grant("R3 boot uni erase", EU, 19'h7F000, 1'b0);
        expect_grant("R3 neighbour free", PG, 19'h6FFFF, 1'b1);
        expect_grant("R3 read free", RD, 19'h70000, 1'b1);
        boot_lock_n = 1'b1;
        expect_grant("R4 pin left regs clear", PG, 19'h70000, 1'b1);
        set_lock(4'd10, 2'b01);
        expect_grant("R4 reg lock applies", PG, 19'h70000, 1'b0);
        @(negedge clk); boot_lock_n = 1'b0;
        @(negedge clk); boot_lock_n = 1'b1;
        expect_grant("R4 toggle keeps lock", EU, 19'h70000, 1'b0);
    endtask

    task automatic t_init();
        set_lock(4'd7, 2'b01);
        expect_grant("R6 sector7 locked", PG, 19'h40000, 1'b0);
        @(negedge clk);
        init_n = 1'b0; req_valid = 1'b1; req_op = PG; req_addr = 19'h40000;
        @(negedge clk);
        chk("R9 init quiet", rsp_valid, 0);
        init_n = 1'b1; req_valid = 1'b0;
        expect_grant("R9 init clears lock", PG, 19'h40000, 1'b1);
        expect_grant("R9 init clears top lock", PG, 19'h70000, 1'b1);
    endtask

    task automatic t_mode();
        @(negedge clk); iface_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 mode held while live", host_mode, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); iface_sel = 1'b1;
        @(negedge clk);
        chk("R10 mode recaptured", host_mode, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_part_map();
        t_uni_map();
        t_locks();
        t_uni_block0();
        t_bad_index();
        t_reset_clear();
        t_wp();
        t_boot();
        t_init();
        t_mode();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule